// File: doc/BRIEF.md
# Boot-overlay address decoder

This block is the glue logic between an 8-bit coprocessor CPU, a 64K RAM, a 4K boot ROM and a host interface register block. From the 16-bit CPU address, the read/write line and the two bus-status pins, it derives three active-low chip selects. It also drives the active-low read and write strobes for the interface and a modified address bit 8 for the memories. That bit is inverted while the CPU fetches an interrupt or reset vector, so vectors are read from 0xFEFx rather than 0xFFFx.

A single overlay flag controls the memory map. Reset sets the flag. While it is set, every read outside the interface window goes to the boot ROM, which decodes only the low twelve address bits and so is mirrored across the whole read space. Writes always go to RAM. The startup code copies the ROM image into the RAM underneath it and then touches the interface window. That access clears the flag on the falling edge of E that ends the cycle, and from the next cycle onward reads are served from RAM. An optional build mode sends reads with A15 = 0 to RAM even while the overlay is active, so a stack in low memory works before the ROM is switched out.

Top module: `bootmap_decoder`

## Requirements
- R1: An access with address in 0xFEE0 to 0xFEEF drives `host_cs_n` low, and `ram_cs_n` and `rom_cs_n` both stay high in that cycle.
- R2: When `ba` = 0 and `bs` = 1 (vector fetch), `a8_mem` is the inverse of `addr[8]`. For the other three `ba`/`bs` combinations, `a8_mem` equals `addr[8]`.
- R3: A write (`rnw` = 0) outside the interface window drives `ram_cs_n` low, whether the overlay is active or not.
- R4: While `rst_n` is low and after it, until an interface access, every read outside the interface window drives `rom_cs_n` low at any address with A15 = 1. With `LOW_RAM_EN` = 0 this also holds for any address with A15 = 0.
- R5: An interface access leaves the decode of its own cycle unchanged. It clears the overlay on the falling edge of `clk_e` that ends that cycle, and every later read outside the window drives `ram_cs_n` low.
- R6: `host_rd_n` is low exactly when `clk_e` is high and `rnw` = 1.
- R7: `host_wr_n` is low exactly when `clk_e` is high and `rnw` = 0.
- R8: With `LOW_RAM_EN` = 1, a read with A15 = 0 selects RAM even while the overlay is active. Reads with A15 = 1 still select the ROM.
- R9: Once cleared, the overlay stays cleared until `rst_n` is sampled low on a falling edge of `clk_e`, which sets it again.
- R10: In every cycle exactly one of `ram_cs_n`, `rom_cs_n` and `host_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_e | input | 1 | CPU E clock; high during the data phase of a bus cycle |
| rst_n | input | 1 | Active-low reset, sampled on the falling edge of `clk_e` |
| addr | input | 16 | CPU address bus |
| rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| ba | input | 1 | CPU bus-available status pin |
| bs | input | 1 | CPU bus-status pin |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | Boot ROM chip select, active low |
| host_cs_n | output | 1 | Interface register chip select, active low |
| host_rd_n | output | 1 | Interface read strobe, active low |
| host_wr_n | output | 1 | Interface write strobe, active low |
| a8_mem | output | 1 | Address bit 8 as presented to the RAM and ROM |

## Verification
The chip selects and `a8_mem` depend only on the inputs and the overlay flag, so they are due in the same cycle as the stimulus. The bench applies each stimulus just after a falling edge and samples it in the E-high phase that follows. The strobes are checked twice per cycle: once in the high phase against `rnw`, and once in the low phase, where both must be high. An interface access affects the selects one cycle later, because the flag changes on the falling edge that ends the access. The bench's own flag model updates at that same edge, before the next stimulus is applied, so the effect of an access is checked in the cycle after it and not in the access cycle itself.

// File: rtl/bootmap_pkg.sv
`timescale 1ns/1ps
// bootmap_pkg: types and helpers shared by the boot-overlay decoder.
// Assumes the bus status is presented as the pair {ba, bs}.
package bootmap_pkg;

    // CPU bus status, encoded as {ba, bs}
    typedef enum logic [1:0] {
        BST_RUN    = 2'b00,
        BST_VECTOR = 2'b01,
        BST_SYNC   = 2'b10,
        BST_HALT   = 2'b11
    } bus_state_t;

    // Internal select vector, active high
    typedef struct packed {
        logic ram;
        logic rom;
        logic host;
    } mem_sel_t;

    // True when the status pins report a vector fetch
    function automatic logic is_vector_fetch(input bus_state_t st);
        return st == BST_VECTOR;
    endfunction

endpackage

// File: rtl/bootmap_window.sv
`timescale 1ns/1ps
// bootmap_window: flags an access that falls inside the interface window.
// Assumes the window is aligned to its own size, so only the tag bits
// above the window offset take part in the compare.
module bootmap_window #(
    parameter int               TAG_W = 12,
    parameter logic [TAG_W-1:0] TAG   = 12'hFEE
) (
    input  logic [TAG_W-1:0] addr_tag,
    output logic             win_hit
);

    // Compare the upper address bits with the window tag
    always_comb begin
        win_hit = (addr_tag == TAG);
    end

endmodule

// File: rtl/bootmap_vector_remap.sv
`timescale 1ns/1ps
// bootmap_vector_remap: inverts one memory address bit during a vector
// fetch, so vectors are read from a relocated page.
// Assumes the status pins are stable for the whole bus cycle.
module bootmap_vector_remap
    import bootmap_pkg::*;
(
    input  bus_state_t bus_st,
    input  logic       bit_in,
    output logic       bit_out
);

    // Flip the chosen bit only for a vector fetch
    always_comb begin
        bit_out = bit_in ^ is_vector_fetch(bus_st);
    end

endmodule

// File: rtl/bootmap_overlay.sv
`timescale 1ns/1ps
// bootmap_overlay: the single state bit of the decoder. Reset sets it and
// an interface access clears it. It updates on the falling edge of E, so
// the cycle that causes a change keeps its own decode.
// Assumes rst_n is synchronous to E.
module bootmap_overlay (
    input  logic clk_e,
    input  logic rst_n,
    input  logic win_hit,
    output logic overlay_q
);

    // Set on reset, clear at the end of any interface cycle
    always_ff @(negedge clk_e) begin
        if (!rst_n) begin
            overlay_q <= 1'b1;
        end else if (win_hit) begin
            overlay_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bootmap_select.sv
`timescale 1ns/1ps
// bootmap_select: picks exactly one of RAM, ROM or interface for the
// current bus cycle. The interface wins in its window. Otherwise reads go
// to the ROM while the overlay is set, and everything else goes to RAM.
// With LOW_RAM_EN set, reads with the top address bit clear bypass the
// overlay and go to RAM.
module bootmap_select
    import bootmap_pkg::*;
#(
    parameter bit LOW_RAM_EN = 1'b0
) (
    input  logic     win_hit,
    input  logic     rnw,
    input  logic     overlay,
    input  logic     addr_msb,
    output mem_sel_t sel
);

    logic low_bypass;
    logic rom_read;

    // Choose whether the low half escapes the overlay
    generate
        if (LOW_RAM_EN) begin : g_low_ram
            assign low_bypass = ~addr_msb;
        end else begin : g_no_low_ram
            assign low_bypass = 1'b0 & addr_msb;
        end
    endgenerate

    // Decide ROM versus RAM, then let the interface window override both
    always_comb begin
        rom_read = rnw & overlay & ~low_bypass;
        sel.host = win_hit;
        sel.rom  = ~win_hit & rom_read;
        sel.ram  = ~win_hit & ~rom_read;
    end

endmodule

// File: rtl/bootmap_strobe.sv
`timescale 1ns/1ps
// bootmap_strobe: active-low interface strobes, each the NAND of E with
// the read/write line or its inverse.
// Assumes the interface block qualifies the strobes with its own select.
module bootmap_strobe (
    input  logic clk_e,
    input  logic rnw,
    output logic rd_n,
    output logic wr_n
);

    // Gate the direction line with the data phase of E
    always_comb begin
        rd_n = ~(clk_e & rnw);
        wr_n = ~(clk_e & ~rnw);
    end

endmodule

// File: rtl/bootmap_decoder.sv
`timescale 1ns/1ps
// bootmap_decoder: top of the boot-overlay address decoder. It combines
// the window compare, the overlay flag, the select logic, the vector
// remap and the strobes. All outputs except the flag are combinational.
// Assumes a single bus master and a synchronous reset timed to E.
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter int               WIN_BITS   = 4,
    parameter logic [ADDR_W-1:0] HOST_BASE = 16'hFEE0,
    parameter int               REMAP_BIT  = 8,
    parameter bit               LOW_RAM_EN = 1'b0
) (
    input  logic              clk_e,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              ba,
    input  logic              bs,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic              host_cs_n,
    output logic              host_rd_n,
    output logic              host_wr_n,
    output logic              a8_mem
);

    localparam int TAG_W = ADDR_W - WIN_BITS;
    localparam logic [TAG_W-1:0] WIN_TAG = HOST_BASE[ADDR_W-1:WIN_BITS];

    logic       win_hit;
    logic       overlay_q;
    mem_sel_t   sel;
    bus_state_t bus_st;

    // Pack the status pins into the bus-state encoding
    always_comb begin
        bus_st = bus_state_t'({ba, bs});
    end

    bootmap_window #(
        .TAG_W (TAG_W),
        .TAG   (WIN_TAG)
    ) u_window (
        .addr_tag (addr[ADDR_W-1:WIN_BITS]),
        .win_hit  (win_hit)
    );

    bootmap_overlay u_overlay (
        .clk_e     (clk_e),
        .rst_n     (rst_n),
        .win_hit   (win_hit),
        .overlay_q (overlay_q)
    );

    bootmap_select #(
        .LOW_RAM_EN (LOW_RAM_EN)
    ) u_select (
        .win_hit  (win_hit),
        .rnw      (rnw),
        .overlay  (overlay_q),
        .addr_msb (addr[ADDR_W-1]),
        .sel      (sel)
    );

    bootmap_vector_remap u_remap (
        .bus_st  (bus_st),
        .bit_in  (addr[REMAP_BIT]),
        .bit_out (a8_mem)
    );

    bootmap_strobe u_strobe (
        .clk_e (clk_e),
        .rnw   (rnw),
        .rd_n  (host_rd_n),
        .wr_n  (host_wr_n)
    );

    // Drive the active-low chip selects
    always_comb begin
        ram_cs_n  = ~sel.ram;
        rom_cs_n  = ~sel.rom;
        host_cs_n = ~sel.host;
    end

endmodule

// File: rtl/bootmap_decoder_chk.sv
`timescale 1ns/1ps
// bootmap_decoder_chk: temporal checks on the decoder ports and its
// overlay flag. It is attached to every decoder instance by bind.
module bootmap_decoder_chk #(
    parameter bit LOW_RAM_EN = 1'b0
) (
    input logic clk_e,
    input logic rst_n,
    input logic rnw,
    input logic ba,
    input logic bs,
    input logic addr_msb,
    input logic addr8,
    input logic ram_cs_n,
    input logic rom_cs_n,
    input logic host_cs_n,
    input logic host_rd_n,
    input logic host_wr_n,
    input logic a8_mem,
    input logic overlay_q
);

    assert_host_excl_R1: assert property (@(posedge clk_e) disable iff (!rst_n)
        !host_cs_n |-> (ram_cs_n && rom_cs_n));

    assert_vector_flip_R2: assert property (@(posedge clk_e) disable iff (!rst_n)
        (!ba && bs) |-> (a8_mem != addr8));

    assert_vector_pass_R2: assert property (@(posedge clk_e) disable iff (!rst_n)
        !(!ba && bs) |-> (a8_mem == addr8));

    assert_write_ram_R3: assert property (@(posedge clk_e) disable iff (!rst_n)
        (host_cs_n && !rnw) |-> !ram_cs_n);

    assert_overlay_rom_R4: assert property (@(posedge clk_e) disable iff (!rst_n)
        (overlay_q && rnw && host_cs_n && (!LOW_RAM_EN || addr_msb)) |-> !rom_cs_n);

    assert_clear_on_access_R5: assert property (@(negedge clk_e) disable iff (!rst_n)
        !host_cs_n |=> !overlay_q);

    assert_ram_after_clear_R5: assert property (@(posedge clk_e) disable iff (!rst_n)
        (!overlay_q && host_cs_n) |-> !ram_cs_n);

    assert_low_ram_R8: assert property (@(posedge clk_e) disable iff (!rst_n)
        (LOW_RAM_EN && rnw && host_cs_n && !addr_msb) |-> !ram_cs_n);

    assert_reset_sets_R9: assert property (@(negedge clk_e)
        !rst_n |=> overlay_q);

    assert_stays_clear_R9: assert property (@(negedge clk_e) disable iff (!rst_n)
        !overlay_q |=> !overlay_q);

    assert_one_select_R10: assert property (@(posedge clk_e) disable iff (!rst_n)
        $countones({ram_cs_n, rom_cs_n, host_cs_n}) == 2);

    // Strobes never both active, and both idle while E is low
    always_comb begin
        if (rst_n === 1'b1) begin
            assert_strobe_excl_R6: assert (host_rd_n || host_wr_n);
            assert_strobe_idle_R7: assert (clk_e || (host_rd_n && host_wr_n));
        end
    end

endmodule

bind bootmap_decoder bootmap_decoder_chk #(
    .LOW_RAM_EN (LOW_RAM_EN)
) u_chk (
    .clk_e     (clk_e),
    .rst_n     (rst_n),
    .rnw       (rnw),
    .ba        (ba),
    .bs        (bs),
    .addr_msb  (addr[ADDR_W-1]),
    .addr8     (addr[REMAP_BIT]),
    .ram_cs_n  (ram_cs_n),
    .rom_cs_n  (rom_cs_n),
    .host_cs_n (host_cs_n),
    .host_rd_n (host_rd_n),
    .host_wr_n (host_wr_n),
    .a8_mem    (a8_mem),
    .overlay_q (overlay_q)
);

// File: tb/bootmap_decoder_test.sv
`timescale 1ns/1ps
// bootmap_decoder_test: scoreboard bench. The driver applies one bus
// cycle per E period and queues the expected outputs. The monitor pops
// and compares them in the E-high phase. Two instances run side by side:
// the default build and the low-RAM build.
module bootmap_decoder_test;

    logic        clk_e = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr  = 16'h0000;
    logic        rnw   = 1'b1;
    logic        ba    = 1'b0;
    logic        bs    = 1'b0;

    logic ram_cs_n, rom_cs_n, host_cs_n, host_rd_n, host_wr_n, a8_mem;
    logic lr_ram_cs_n, lr_rom_cs_n, lr_host_cs_n, lr_rd_n, lr_wr_n, lr_a8;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    typedef struct {
        string tag;
        logic  ram, rom, host, a8, rd, wr;
        logic  lr_ram, lr_rom;
    } exp_t;

    exp_t sb_q[$];

    // Bench model state
    logic ovl_m   = 1'b1;
    logic prv_rst = 1'b0;
    logic prv_hit = 1'b0;

    always #5 clk_e = ~clk_e;

    bootmap_decoder uut (
        .clk_e (clk_e), .rst_n (rst_n), .addr (addr), .rnw (rnw),
        .ba (ba), .bs (bs),
        .ram_cs_n (ram_cs_n), .rom_cs_n (rom_cs_n), .host_cs_n (host_cs_n),
        .host_rd_n (host_rd_n), .host_wr_n (host_wr_n), .a8_mem (a8_mem)
    );

    bootmap_decoder #(.LOW_RAM_EN (1'b1)) uut_lr (
        .clk_e (clk_e), .rst_n (rst_n), .addr (addr), .rnw (rnw),
        .ba (ba), .bs (bs),
        .ram_cs_n (lr_ram_cs_n), .rom_cs_n (lr_rom_cs_n), .host_cs_n (lr_host_cs_n),
        .host_rd_n (lr_rd_n), .host_wr_n (lr_wr_n), .a8_mem (lr_a8)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Driver: one bus cycle, expected outputs pushed to the scoreboard
    task automatic cycle(input logic r, input logic [15:0] a, input logic w,
                         input logic b_a, input logic b_s, input string tag);
        exp_t e;
        logic hit;
        logic rom_d;
        logic rom_l;
        @(negedge clk_e);
        if (!prv_rst)     ovl_m = 1'b1;
        else if (prv_hit) ovl_m = 1'b0;
        #1;
        rst_n = r; addr = a; rnw = w; ba = b_a; bs = b_s;
        hit   = (a[15:4] == 12'hFEE);
        rom_d = !hit && w && ovl_m;
        rom_l = rom_d && a[15];
        e.tag    = tag;
        e.host   = !hit;
        e.rom    = !rom_d;
        e.ram    = !(!hit && !rom_d);
        e.lr_rom = !rom_l;
        e.lr_ram = !(!hit && !rom_l);
        e.a8     = a[8] ^ (!b_a && b_s);
        e.rd     = !w;
        e.wr     = w;
        prv_rst = r;
        prv_hit = hit;
        sb_q.push_back(e);
        started = 1'b1;
    endtask

    // Monitor: compare in the E-high phase of each cycle
    initial begin
        exp_t e;
        forever begin
            @(posedge clk_e);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check(e.tag, "host_cs_n", host_cs_n, e.host);
                check(e.tag, "rom_cs_n", rom_cs_n, e.rom);
                check(e.tag, "ram_cs_n", ram_cs_n, e.ram);
                check(e.tag, "a8_mem", a8_mem, e.a8);
                check("R6", "host_rd_n high phase", host_rd_n, e.rd);
                check("R7", "host_wr_n high phase", host_wr_n, e.wr);
                check(e.tag, "lowram rom_cs_n", lr_rom_cs_n, e.lr_rom);
                check(e.tag, "lowram ram_cs_n", lr_ram_cs_n, e.lr_ram);
                check("R10", "one select", 1'(((!ram_cs_n) + (!rom_cs_n) + (!host_cs_n)) == 2'd1), 1'b1);
            end
        end
    end

    // Low-phase strobe check: both idle while E is low
    initial begin
        forever begin
            @(negedge clk_e);
            #3;
            if (started) begin
                check("R6", "host_rd_n low phase", host_rd_n, 1'b1);
                check("R7", "host_wr_n low phase", host_wr_n, 1'b1);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin
        // Reset state: overlay set, reads to ROM (R4)
        cycle(1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, "R4 reset read");
        cycle(1'b0, 16'hF000, 1'b1, 1'b0, 1'b0, "R4 reset read");
        // Overlay reads mirrored everywhere; low half depends on build (R4, R8)
        cycle(1'b1, 16'hF000, 1'b1, 1'b0, 1'b0, "R4 overlay read high");
        cycle(1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, "R4 overlay read 8000");
        cycle(1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, "R8 overlay read low");
        cycle(1'b1, 16'h7ABC, 1'b1, 1'b0, 1'b0, "R8 overlay read low");
        // Writes always RAM (R3)
        cycle(1'b1, 16'h2000, 1'b0, 1'b0, 1'b0, "R3 write low");
        cycle(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 write top");
        // Vector remap over all status codes (R2)
        cycle(1'b1, 16'hFFFE, 1'b1, 1'b0, 1'b1, "R2 vector fetch");
        cycle(1'b1, 16'hFFFE, 1'b1, 1'b1, 1'b1, "R2 halt passes");
        cycle(1'b1, 16'hFFFE, 1'b1, 1'b0, 1'b0, "R2 run passes");
        cycle(1'b1, 16'hFEF0, 1'b1, 1'b1, 1'b0, "R2 sync passes");
        cycle(1'b1, 16'hFEF0, 1'b1, 1'b0, 1'b1, "R2 vector bit8 low");
        // Window edges, overlay still set (R1, R4)
        cycle(1'b1, 16'hFEDF, 1'b1, 1'b0, 1'b0, "R1 below window");
        cycle(1'b1, 16'hFEF0, 1'b1, 1'b0, 1'b0, "R1 above window");
        // Interface read: its own cycle keeps decode (R1, R5)
        cycle(1'b1, 16'hFEE0, 1'b1, 1'b0, 1'b0, "R1 window read");
        cycle(1'b1, 16'hF000, 1'b1, 1'b0, 1'b0, "R5 read after clear");
        cycle(1'b1, 16'hFEEF, 1'b0, 1'b0, 1'b0, "R1 window write");
        cycle(1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, "R5 read low ram");
        cycle(1'b1, 16'hFFFE, 1'b1, 1'b0, 1'b1, "R5 vector from ram");
        // Overlay stays clear (R9)
        for (int i = 0; i < 4; i++) begin
            cycle(1'b1, 16'(16'hC000 + i * 16'h0111), 1'b1, 1'b0, 1'b0, "R9 stays clear");
        end
        cycle(1'b1, 16'h4000, 1'b0, 1'b0, 1'b0, "R3 write after clear");
        // Second reset restores the overlay (R9)
        cycle(1'b0, 16'hE000, 1'b1, 1'b0, 1'b0, "R9 reset again");
        cycle(1'b1, 16'hE000, 1'b1, 1'b0, 1'b0, "R9 overlay restored");
        cycle(1'b1, 16'h0042, 1'b1, 1'b0, 1'b0, "R8 low read again");
        cycle(1'b1, 16'hFEE5, 1'b0, 1'b0, 1'b0, "R1 window write in overlay");
        cycle(1'b1, 16'h1000, 1'b1, 1'b0, 1'b0, "R5 ram after write access");
        cycle(1'b1, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R5 ram top");
        repeat (3) @(posedge clk_e);
        #4;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule